// File: doc/BRIEF.md
# Packed SIMD Integer Unit with Per-Instruction Control Field

This block performs lane-parallel integer arithmetic on packed operands. Each request carries its own 12-bit control word. The word selects the vector length, the lane width, how results that overflow are treated, and the operation. No vector state is set up ahead of time, so back-to-back requests can use entirely different lane shapes with no penalty.

Execution runs on a datapath half as wide as the full vector. A short vector passes through it once. A full-width vector passes through it twice, low half first, and the unit holds off new work between the two passes. A control word that names a reserved size, the floating-point category or an undefined operation produces no arithmetic result. The unit instead returns a flagged, zeroed response on the normal result timing.

Top module: `simd_ctl_alu`

## Requirements
- R1: The control word is split as bits [11:10] vector length (0 = 64-bit, 1 = 128-bit), bits [9:8] lane width (0..3 = 8, 16, 32, 64 bits), bits [7:6] category (0 = modulo, 1 = floating point, 2 = signed saturating, 3 = unsigned saturating) and bits [5:0] operation (0 = add, 1 = subtract, 2 = multiply low, 3 = multiply high, 4 = multiply-accumulate).
- R2: A vector-length code of 2 or 3, category 1, or an operation code above 4 is illegal. One cycle after it is accepted, out_valid and out_illegal are both 1 and out_data is all zero.
- R3: In the modulo category, each lane result is the low n bits of the exact result, and no carry or borrow crosses a lane boundary at any lane width.
- R4: In the signed saturating category, add, subtract, multiply low and multiply-accumulate clamp each lane to [-2^(n-1), 2^(n-1)-1].
- R5: In the unsigned saturating category, the same operations clamp each lane to [0, 2^n-1], so a subtraction that would go negative gives 0.
- R6: Multiply high returns bits [2n-1:n] of the lane product, with no clamping. The operands are treated as signed in category 2 and as unsigned otherwise.
- R7: Multiply-accumulate computes opc + opa*opb per lane, and the category's clamping applies to the sum.
- R8: A 64-bit legal request has its result on out_valid one cycle after acceptance, and out_data bits [127:64] are zero.
- R9: A 128-bit legal request has its result two cycles after acceptance. During the cycle in between, in_ready is 0, out_valid is 0, and any request presented is ignored.
- R10: After reset, out_valid and out_illegal are 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| ctrl | input | 12 | Per-request control word |
| opa | input | 128 | First operand |
| opb | input | 128 | Second operand |
| opc | input | 128 | Accumulator operand |
| out_valid | output | 1 | Result present for one cycle |
| out_illegal | output | 1 | Request was an illegal combination |
| out_data | output | 128 | Packed result |

## Verification
The hardest situation to reach from the ports is a second request arriving while the upper half of a full-width vector is still pending. The unit must ignore it and not corrupt the saved upper operands. The stimulus holds in_valid high with different operands and a different control word through the pending cycle. It then checks two things: that the completed result matches the first request, and that no extra result follows. A sweep over every legal lane width, category and operation, at both vector lengths, checks the lane boundaries and clamp limits against a reference model.

// File: rtl/simd_pkg.sv
package simd_pkg;
   localparam int CTL_W = 12;

   localparam logic [1:0] VS_HALF = 2'd0;
   localparam logic [1:0] VS_FULL = 2'd1;

   localparam logic [1:0] CAT_WRAP  = 2'd0;
   localparam logic [1:0] CAT_FLOAT = 2'd1;
   localparam logic [1:0] CAT_SSAT  = 2'd2;
   localparam logic [1:0] CAT_USAT  = 2'd3;

   localparam logic [5:0] OP_ADD   = 6'd0;
   localparam logic [5:0] OP_SUB   = 6'd1;
   localparam logic [5:0] OP_MUL   = 6'd2;
   localparam logic [5:0] OP_MULHI = 6'd3;
   localparam logic [5:0] OP_MAC   = 6'd4;

   typedef struct packed {
      logic [1:0] vlen;
      logic [1:0] esel;
      logic [1:0] cat;
      logic [5:0] op;
   } ctl_t;

   function automatic logic ctl_legal(ctl_t c);
      return (c.vlen == VS_HALF || c.vlen == VS_FULL) &&
             (c.cat != CAT_FLOAT) && (c.op <= OP_MAC);
   endfunction
endpackage

// File: rtl/simd_lane.sv
module simd_lane
   import simd_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] c,
   input  logic [1:0]   cat,
   input  logic [5:0]   op,
   output logic [W-1:0] y
);
   localparam int E = 2 * W + 2;
   localparam logic signed [E-1:0] S_MAX = E'({(W-1){1'b1}});
   localparam logic signed [E-1:0] S_MIN = ~S_MAX;
   localparam logic signed [E-1:0] U_MAX = E'({W{1'b1}});

   if (W < 2) begin : g_bad_w
      $error("simd_lane: W must be at least 2");
   end

   logic                  sgn;
   logic signed [E-1:0]   ax, bx, cx, prod, full, lim_hi, lim_lo;

   always_comb begin
      sgn    = (cat == CAT_SSAT);
      ax     = sgn ? {{(E-W){a[W-1]}}, a} : {{(E-W){1'b0}}, a};
      bx     = sgn ? {{(E-W){b[W-1]}}, b} : {{(E-W){1'b0}}, b};
      cx     = sgn ? {{(E-W){c[W-1]}}, c} : {{(E-W){1'b0}}, c};
      prod   = ax * bx;
      lim_hi = sgn ? S_MAX : U_MAX;
      lim_lo = sgn ? S_MIN : '0;
      case (op)
         OP_ADD:            full = ax + bx;
         OP_SUB:            full = ax - bx;
         OP_MUL, OP_MULHI:  full = prod;
         OP_MAC:            full = cx + prod;
         default:           full = '0;
      endcase
      y = full[W-1:0];
      if (op == OP_MULHI) begin
         y = full[2*W-1:W];
      end else if (cat == CAT_SSAT || cat == CAT_USAT) begin
         if (full > lim_hi)      y = lim_hi[W-1:0];
         else if (full < lim_lo) y = lim_lo[W-1:0];
      end
   end
endmodule

// File: rtl/simd_dp.sv
module simd_dp
   import simd_pkg::*;
#(
   parameter int DP_W    = 64,
   parameter int N_WIDTH = 4
) (
   input  logic [DP_W-1:0] a,
   input  logic [DP_W-1:0] b,
   input  logic [DP_W-1:0] c,
   input  logic [1:0]      esel,
   input  logic [1:0]      cat,
   input  logic [5:0]      op,
   output logic [DP_W-1:0] y
);
   localparam int MAX_LANE = 8 << (N_WIDTH - 1);

   if (N_WIDTH != 4 || DP_W % MAX_LANE != 0) begin : g_bad_cfg
      $error("simd_dp: need four lane widths and DP_W a multiple of 64");
   end

   logic [N_WIDTH-1:0][DP_W-1:0] by_w;

   for (genvar g = 0; g < N_WIDTH; g++) begin : g_width
      localparam int W = 8 << g;
      localparam int N = DP_W / W;
      for (genvar k = 0; k < N; k++) begin : g_lane
         simd_lane #(.W(W)) u_lane (
            .a   (a[k*W +: W]),
            .b   (b[k*W +: W]),
            .c   (c[k*W +: W]),
            .cat (cat),
            .op  (op),
            .y   (by_w[g][k*W +: W])
         );
      end
   end

   assign y = by_w[esel];
endmodule

// File: rtl/simd_ctl_alu.sv
module simd_ctl_alu
   import simd_pkg::*;
#(
   parameter int DATA_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [CTL_W-1:0]  ctrl,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [DATA_W-1:0] opc,
   output logic              out_valid,
   output logic              out_illegal,
   output logic [DATA_W-1:0] out_data
);
   localparam int HALF = DATA_W / 2;

   if (DATA_W != 128) begin : g_bad_w
      $error("simd_ctl_alu: DATA_W must be 128 (two 64-bit passes)");
   end

   ctl_t            cin;
   logic            legal, accept, pend;
   logic [HALF-1:0] a_hi, b_hi, c_hi, lo_q, dp_a, dp_b, dp_c, dp_y;
   logic [1:0]      q_esel, q_cat, dp_esel, dp_cat;
   logic [5:0]      q_op, dp_op;

   assign cin      = ctl_t'(ctrl);
   assign legal    = ctl_legal(cin);
   assign in_ready = !pend;
   assign accept   = in_valid && in_ready;

   always_comb begin
      if (pend) begin
         dp_a = a_hi;  dp_b = b_hi;  dp_c = c_hi;
         dp_esel = q_esel;  dp_cat = q_cat;  dp_op = q_op;
      end else begin
         dp_a = opa[HALF-1:0];  dp_b = opb[HALF-1:0];  dp_c = opc[HALF-1:0];
         dp_esel = cin.esel;  dp_cat = cin.cat;  dp_op = cin.op;
      end
   end

   simd_dp #(.DP_W(HALF), .N_WIDTH(4)) u_dp (
      .a    (dp_a),
      .b    (dp_b),
      .c    (dp_c),
      .esel (dp_esel),
      .cat  (dp_cat),
      .op   (dp_op),
      .y    (dp_y)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend        <= 1'b0;
         out_valid   <= 1'b0;
         out_illegal <= 1'b0;
         out_data    <= '0;
      end else begin
         out_valid   <= 1'b0;
         out_illegal <= 1'b0;
         if (pend) begin
            out_data  <= {dp_y, lo_q};
            out_valid <= 1'b1;
            pend      <= 1'b0;
         end else if (accept) begin
            if (!legal) begin
               out_valid   <= 1'b1;
               out_illegal <= 1'b1;
               out_data    <= '0;
            end else if (cin.vlen == VS_FULL) begin
               pend <= 1'b1;
            end else begin
               out_valid <= 1'b1;
               out_data  <= {{HALF{1'b0}}, dp_y};
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (accept && legal && cin.vlen == VS_FULL) begin
         lo_q   <= dp_y;
         a_hi   <= opa[DATA_W-1:HALF];
         b_hi   <= opb[DATA_W-1:HALF];
         c_hi   <= opc[DATA_W-1:HALF];
         q_esel <= cin.esel;
         q_cat  <= cin.cat;
         q_op   <= cin.op;
      end
   end

   a_r2_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> (out_valid && out_data == '0));
   a_r2_illegal_next: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !legal) |=> out_illegal);
   a_r8_single_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && legal && cin.vlen == VS_HALF) |=>
         (out_valid && out_data[DATA_W-1:HALF] == '0));
   a_r9_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && legal && cin.vlen == VS_FULL) |=> (!in_ready && !out_valid));
   a_r9_complete: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |=> (out_valid && in_ready && !out_illegal));
endmodule

// File: tb/sim_simd_ctl_alu.sv
module sim_simd_ctl_alu;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [11:0]  ctrl = '0;
   logic [127:0] opa = '0, opb = '0, opc = '0;
   logic         out_valid, out_illegal;
   logic [127:0] out_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   simd_ctl_alu u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .ctrl(ctrl), .opa(opa), .opb(opb), .opc(opc),
      .out_valid(out_valid), .out_illegal(out_illegal), .out_data(out_data)
   );

   function automatic logic [11:0] mk(int vl, int es, int cat, int op);
      return {2'(vl), 2'(es), 2'(cat), 6'(op)};
   endfunction

   function automatic logic [63:0] ref_lane(logic [63:0] a, logic [63:0] b,
                                            logic [63:0] c, int n, int cat, int op);
      logic signed [131:0] m, ax, bx, cx, p, f, hi, lo;
      m  = (132'sd1 <<< n) - 132'sd1;
      ax = a & m;  bx = b & m;  cx = c & m;
      if (cat == 2 && a[n-1]) ax = ax | ~m;
      if (cat == 2 && b[n-1]) bx = bx | ~m;
      if (cat == 2 && c[n-1]) cx = cx | ~m;
      p = ax * bx;
      case (op)
         0: f = ax + bx;
         1: f = ax - bx;
         2: f = p;
         3: f = p >>> n;
         default: f = cx + p;
      endcase
      if (op != 3 && (cat == 2 || cat == 3)) begin
         hi = (cat == 2) ? (m >>> 1) : m;
         lo = (cat == 2) ? (-hi - 132'sd1) : 132'sd0;
         if (f > hi) f = hi;
         else if (f < lo) f = lo;
      end
      return 64'(f & m);
   endfunction

   function automatic logic [127:0] model(logic [11:0] c, logic [127:0] a,
                                          logic [127:0] b, logic [127:0] acc);
      int n = 8 << c[9:8];
      int halves = (c[11:10] == 2'd1) ? 2 : 1;
      logic [127:0] r = '0;
      for (int h = 0; h < halves; h++) begin
         for (int k = 0; k < 64 / n; k++) begin
            int off = h * 64 + k * n;
            r = r | ({64'b0, ref_lane(64'(a >> off), 64'(b >> off), 64'(acc >> off),
                                      n, int'(c[7:6]), int'(c[5:0]))} << off);
         end
      end
      return r;
   endfunction

   task automatic chk(string tag, logic [127:0] got, logic [127:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   // Issue one request and return the result, checking the timing on the way.
   task automatic run_op(string tag, logic [11:0] c, logic [127:0] a,
                         logic [127:0] b, logic [127:0] acc,
                         output logic [127:0] res, output logic ill);
      @(negedge clk);
      ctrl = c; opa = a; opb = b; opc = acc; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      if (c[11:10] == 2'd1 && c[7:6] != 2'd1 && c[5:0] <= 6'd4) begin
         chk({tag, " R9 gap"}, {126'b0, in_ready, out_valid}, 128'd0);
         @(negedge clk);
      end
      chk({tag, " valid"}, {127'b0, out_valid}, 128'd1);
      res = out_data;
      ill = out_illegal;
   endtask

   task automatic op_expect(string tag, logic [11:0] c, logic [127:0] a,
                            logic [127:0] b, logic [127:0] acc);
      logic [127:0] r;
      logic il;
      run_op(tag, c, a, b, acc, r, il);
      chk({tag, " legal"}, {127'b0, il}, 128'd0);
      chk(tag, r, model(c, a, b, acc));
   endtask

   task automatic t_reset;
      chk("R10 reset", {125'b0, out_valid, out_illegal, in_ready}, 128'd1);
   endtask

   task automatic t_wrap;
      logic [127:0] r;
      logic il;
      run_op("R3 add8 carry", mk(0, 0, 0, 0), {64'b0, {8{8'hFF}}},
             {64'b0, {8{8'h01}}}, '0, r, il);
      chk("R3 add8 no carry", r, 128'd0);
      run_op("R3 sub16 borrow", mk(0, 1, 0, 1), '0, {64'b0, {4{16'h0001}}}, '0, r, il);
      chk("R3 sub16 no borrow", r, {64'b0, {4{16'hFFFF}}});
   endtask

   task automatic t_sat;
      logic [127:0] r;
      logic il;
      run_op("R4 ssat add", mk(0, 0, 2, 0), {64'b0, {8{8'h7F}}},
             {64'b0, {8{8'h01}}}, '0, r, il);
      chk("R4 ssat add top", r, {64'b0, {8{8'h7F}}});
      run_op("R4 ssat sub", mk(0, 1, 2, 1), {64'b0, {4{16'h8000}}},
             {64'b0, {4{16'h0001}}}, '0, r, il);
      chk("R4 ssat sub floor", r, {64'b0, {4{16'h8000}}});
      run_op("R5 usat sub", mk(0, 0, 3, 1), {64'b0, {8{8'h05}}},
             {64'b0, {8{8'h09}}}, '0, r, il);
      chk("R5 usat sub floor", r, 128'd0);
      run_op("R5 usat mul", mk(0, 2, 3, 2), {64'b0, {2{32'h0001_0000}}},
             {64'b0, {2{32'h0001_0000}}}, '0, r, il);
      chk("R5 usat mul top", r, {64'b0, {2{32'hFFFF_FFFF}}});
   endtask

   task automatic t_mulhi;
      logic [127:0] r;
      logic il;
      run_op("R6 signed hi", mk(0, 0, 2, 3), {64'b0, {8{8'h80}}},
             {64'b0, {8{8'h80}}}, '0, r, il);
      chk("R6 signed hi", r, {64'b0, {8{8'h40}}});
      run_op("R6 unsigned hi", mk(0, 0, 0, 3), {64'b0, {8{8'hFF}}},
             {64'b0, {8{8'hFF}}}, '0, r, il);
      chk("R6 unsigned hi", r, {64'b0, {8{8'hFE}}});
   endtask

   task automatic t_mac;
      logic [127:0] r;
      logic il;
      run_op("R7 mac wrap", mk(0, 1, 0, 4), {64'b0, {4{16'd3}}},
             {64'b0, {4{16'd5}}}, {64'b0, {4{16'd7}}}, r, il);
      chk("R7 mac wrap", r, {64'b0, {4{16'd22}}});
      run_op("R7 mac ssat", mk(0, 0, 2, 4), {64'b0, {8{8'd10}}},
             {64'b0, {8{8'd10}}}, {64'b0, {8{8'd100}}}, r, il);
      chk("R7 mac ssat", r, {64'b0, {8{8'h7F}}});
   endtask

   task automatic t_half_zero;
      logic [127:0] r;
      logic il;
      run_op("R8 upper zero", mk(0, 3, 0, 0), {128{1'b1}}, {128{1'b1}}, '0, r, il);
      chk("R8 upper zero", r, {64'b0, 64'hFFFF_FFFF_FFFF_FFFE});
   endtask

   task automatic t_full_refuse;
      logic [127:0] a, b, exp;
      a = {64'h0102_0304_0506_0708, 64'h1112_1314_1516_1718};
      b = {64'h0101_0101_0101_0101, 64'h0202_0202_0202_0202};
      exp = model(mk(1, 0, 0, 0), a, b, '0);
      @(negedge clk);
      ctrl = mk(1, 0, 0, 0); opa = a; opb = b; opc = '0; in_valid = 1'b1;
      @(negedge clk);
      chk("R9 refuse ready", {127'b0, in_ready}, 128'd0);
      ctrl = mk(0, 2, 3, 1); opa = '1; opb = '0; opc = '1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R9 result", out_data, exp);
      chk("R9 result valid", {126'b0, out_valid, out_illegal}, 128'd2);
      @(negedge clk);
      chk("R9 ignored request", {127'b0, out_valid}, 128'd0);
   endtask

   task automatic t_illegal;
      logic [127:0] r;
      logic il;
      logic [11:0] bad [3];
      bad[0] = mk(2, 0, 0, 0);
      bad[1] = mk(1, 1, 1, 0);
      bad[2] = mk(0, 2, 3, 5);
      for (int i = 0; i < 3; i++) begin
         run_op("R2 illegal", bad[i], '1, '1, '1, r, il);
         chk("R2 flag", {127'b0, il}, 128'd1);
         chk("R2 zero data", r, 128'd0);
      end
   endtask

   task automatic t_sweep;
      logic [127:0] a, b, acc;
      logic [31:0] s = 32'h1234_5678;
      int cats [3] = '{0, 2, 3};
      for (int p = 0; p < 2; p++) begin
         for (int vl = 0; vl < 2; vl++)
            for (int es = 0; es < 4; es++)
               for (int ci = 0; ci < 3; ci++)
                  for (int op = 0; op < 5; op++) begin
                     for (int w = 0; w < 4; w++) begin
                        s = s * 32'd1664525 + 32'd1013904223;
                        a[w*32 +: 32] = s;
                        s = s * 32'd1664525 + 32'd1013904223;
                        b[w*32 +: 32] = s ^ 32'h8080_8080;
                        acc[w*32 +: 32] = s + a[w*32 +: 32];
                     end
                     op_expect("R1 R3 R4 R5 R6 R7 sweep", mk(vl, es, cats[ci], op), a, b, acc);
                  end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_wrap();
      t_sat();
      t_mulhi();
      t_mac();
      t_half_zero();
      t_full_refuse();
      t_illegal();
      t_sweep();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule